// File: doc/BRIEF.md
# Mailbox Error-Count Reader

This block is a bus master that fetches a 32-bit bit-error count from a peripheral that exposes it only through an attribute mailbox on a byte-wide register bus. One pulse on `start_i` runs a fixed handshake. The block stages four request bytes and writes the trigger bit. It then reads the acknowledge flag and polls the busy flag until it drops. It clears the acknowledge flag by writing a one to it, and reads two result bytes. The whole exchange runs twice: the first pass yields the low half of the count, the second the high half.

The result appears on `count_o` together with a one-cycle `done_o` strobe, and only when both passes succeed. Two kinds of failure are reported on sticky flags, and each ends the sequence at once: a missing acknowledge, or a busy flag that stays up for too many polls. Both flags clear when the next sequence is accepted. On the bus the block is a plain master. It holds each command while wait-request is high and takes read data in the cycle after the read is accepted.

Top module: `errcnt_mailbox_reader`

## Requirements
- R1: Each pass begins with four byte writes, in this order: 0x00 to address 0x84, 0x00 to 0x85, 0x1A to 0x86, 0x00 to 0x87.
- R2: Right after the request bytes, the block writes 0x01 (bit 0 set) to address 0x90 to launch the operation.
- R3: The block then reads 0x8A. If bit 7 of that byte is 0, `ack_err_o` goes high and stays high. The block makes no further bus access and asserts no done strobe for that sequence.
- R4: After the acknowledge read, the block reads 0x8B repeatedly until bit 0 of the byte read is 0.
- R5: Once the busy bit reads 0, the block writes 0x80 to 0x8A, which clears the acknowledge flag (bit 7 is write-one-to-clear).
- R6: The block then reads 0x88 as the low byte and 0x89 as the high byte of a 16-bit half. The first pass supplies `count_o[15:0]` and the second pass supplies `count_o[31:16]`.
- R7: Let the limit be `poll_limit_i`, with a value of 0 treated as 1. When the number of busy reads (bit 0 = 1) within one pass reaches the limit, `tmo_err_o` goes high and stays high. The block then stops with no further bus access.
- R8: At most one of `bus_read_o` and `bus_write_o` is high at a time. While wait-request is high, the address, the write data and the command are held unchanged. A read is accepted on a clock edge where it is high and wait-request is low, and its data is taken from `bus_rdata_i` on the following edge only.
- R9: `count_o` changes only in a cycle where `done_o` is high. `done_o` is a single-cycle pulse, given once for each fully successful two-pass sequence and never together with an error flag. After reset `count_o` is 0 and the bus is idle.
- R10: A start pulse that arrives while a sequence is running is ignored. An accepted start clears both error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a two-pass read (ignored when busy) |
| poll_limit_i | input | TMO_W | Busy-read count that triggers a timeout (0 acts as 1) |
| bus_addr_o | output | 8 | Register address |
| bus_wdata_o | output | 8 | Write data |
| bus_write_o | output | 1 | Write command |
| bus_read_o | output | 1 | Read command |
| bus_rdata_i | input | 8 | Read data, valid the cycle after read acceptance |
| bus_waitreq_i | input | 1 | Slave stall; command held while high |
| count_o | output | 32 | Assembled error count |
| done_o | output | 1 | One-cycle strobe when `count_o` updates |
| ack_err_o | output | 1 | Sticky: acknowledge bit was clear |
| tmo_err_o | output | 1 | Sticky: busy polling exceeded the limit |

## Verification
The hardest case to reach is the boundary where the busy-read count and the poll limit meet. One more busy read, or a limit of one less, turns a good result into a timeout, and this has to happen while wait-request stalls the reads. The bench uses a bus slave model whose busy count per pass and whose stall pattern are parameters. It sweeps every pairing of busy count 0..3 and limit 0..3 under three stall patterns: none, alternating, and pseudo-random. For each run it computes the expected access trace, outcome and count arithmetically. Failed acknowledges in either pass and a start pulse issued mid-sequence are added on top of that sweep.

// File: rtl/mbx_reader_pkg.sv
package mbx_reader_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int STEP_W = 4;

  localparam logic [ADDR_W-1:0] A_REQ0  = 8'h84;
  localparam logic [ADDR_W-1:0] A_REQ1  = 8'h85;
  localparam logic [ADDR_W-1:0] A_REQ2  = 8'h86;
  localparam logic [ADDR_W-1:0] A_REQ3  = 8'h87;
  localparam logic [ADDR_W-1:0] A_KICK  = 8'h90;
  localparam logic [ADDR_W-1:0] A_ACK   = 8'h8A;
  localparam logic [ADDR_W-1:0] A_BUSY  = 8'h8B;
  localparam logic [ADDR_W-1:0] A_RES_L = 8'h88;
  localparam logic [ADDR_W-1:0] A_RES_H = 8'h89;

  localparam logic [DATA_W-1:0] SEL_CODE = 8'h1A;

  // sequence positions inside one pass
  localparam logic [STEP_W-1:0] ST_KICK  = 4'd4;
  localparam logic [STEP_W-1:0] ST_ACK   = 4'd5;
  localparam logic [STEP_W-1:0] ST_POLL  = 4'd6;
  localparam logic [STEP_W-1:0] ST_CLR   = 4'd7;
  localparam logic [STEP_W-1:0] ST_LO    = 4'd8;
  localparam logic [STEP_W-1:0] ST_HI    = 4'd9;

  typedef struct packed {
    logic              we;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
  } bus_cmd_t;

  function automatic bus_cmd_t step_cmd(input logic [STEP_W-1:0] s);
    bus_cmd_t c;
    c = '{we: 1'b0, addr: A_ACK, wdata: '0};
    case (s)
      4'd0:    c = '{we: 1'b1, addr: A_REQ0,  wdata: 8'h00};
      4'd1:    c = '{we: 1'b1, addr: A_REQ1,  wdata: 8'h00};
      4'd2:    c = '{we: 1'b1, addr: A_REQ2,  wdata: SEL_CODE};
      4'd3:    c = '{we: 1'b1, addr: A_REQ3,  wdata: 8'h00};
      ST_KICK: c = '{we: 1'b1, addr: A_KICK,  wdata: 8'h01};
      ST_ACK:  c = '{we: 1'b0, addr: A_ACK,   wdata: 8'h00};
      ST_POLL: c = '{we: 1'b0, addr: A_BUSY,  wdata: 8'h00};
      ST_CLR:  c = '{we: 1'b1, addr: A_ACK,   wdata: 8'h80};
      ST_LO:   c = '{we: 1'b0, addr: A_RES_L, wdata: 8'h00};
      ST_HI:   c = '{we: 1'b0, addr: A_RES_H, wdata: 8'h00};
      default: c = '{we: 1'b0, addr: A_ACK,   wdata: 8'h00};
    endcase
    return c;
  endfunction
endpackage

// File: rtl/mbx_bus_port.sv
module mbx_bus_port
  import mbx_reader_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  bus_cmd_t          cmd_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              bus_write_o,
  output logic              bus_read_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_waitreq_i
);
  typedef enum logic [1:0] {P_IDLE, P_ACT, P_DATA} port_st_t;
  port_st_t st;
  bus_cmd_t held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= P_IDLE;
      held <= '0;
    end else begin
      case (st)
        P_IDLE: if (req_i) begin
          held <= cmd_i;
          st   <= P_ACT;
        end
        P_ACT:  if (!bus_waitreq_i) st <= P_DATA;
        default: st <= P_IDLE;
      endcase
    end
  end

  assign bus_addr_o  = held.addr;
  assign bus_wdata_o = held.wdata;
  assign bus_write_o = (st == P_ACT) &&  held.we;
  assign bus_read_o  = (st == P_ACT) && !held.we;
  assign rsp_valid_o = (st == P_DATA);
  assign rsp_data_o  = bus_rdata_i;
endmodule

// File: rtl/mbx_poll_guard.sv
module mbx_poll_guard #(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             hit_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expire_o
);
  localparam int CW = TMO_W + 1;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim_eff;

  assign lim_eff  = (limit_i == '0) ? CW'(1) : {1'b0, limit_i};
  assign expire_o = hit_i && ((cnt + CW'(1)) >= lim_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clr_i)   cnt <= '0;
    else if (hit_i && !(&cnt)) cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/mbx_sequencer.sv
module mbx_sequencer
  import mbx_reader_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              req_o,
  output bus_cmd_t          cmd_o,
  input  logic              rsp_valid_i,
  input  logic [DATA_W-1:0] rsp_data_i,
  output logic              guard_clr_o,
  output logic              guard_hit_o,
  input  logic              guard_expire_i,
  output logic [31:0]       count_o,
  output logic              done_o,
  output logic              ack_err_o,
  output logic              tmo_err_o
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} seq_st_t;
  seq_st_t            st;
  logic [STEP_W-1:0]  step;
  logic               half;
  logic [23:0]        shadow;
  logic               got;

  assign got         = (st == S_WAIT) && rsp_valid_i;
  assign req_o       = (st == S_ISSUE);
  assign cmd_o       = step_cmd(step);
  assign guard_hit_o = got && (step == ST_POLL) && rsp_data_i[0];
  assign guard_clr_o = ((st == S_IDLE) && start_i) ||
                       (got && (step == ST_HI) && !half);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      step      <= '0;
      half      <= 1'b0;
      shadow    <= '0;
      count_o   <= '0;
      done_o    <= 1'b0;
      ack_err_o <= 1'b0;
      tmo_err_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          step      <= '0;
          half      <= 1'b0;
          ack_err_o <= 1'b0;
          tmo_err_o <= 1'b0;
          st        <= S_ISSUE;
        end
        S_ISSUE: st <= S_WAIT;
        default: if (rsp_valid_i) begin
          st   <= S_ISSUE;
          step <= step + STEP_W'(1);
          case (step)
            ST_ACK: if (!rsp_data_i[7]) begin
              ack_err_o <= 1'b1;
              st        <= S_IDLE;
            end
            ST_POLL: if (rsp_data_i[0]) begin
              step <= step;
              if (guard_expire_i) begin
                tmo_err_o <= 1'b1;
                st        <= S_IDLE;
              end
            end
            ST_LO: begin
              if (half) shadow[23:16] <= rsp_data_i;
              else      shadow[7:0]   <= rsp_data_i;
            end
            ST_HI: begin
              if (half) begin
                count_o <= {rsp_data_i, shadow};
                done_o  <= 1'b1;
                st      <= S_IDLE;
              end else begin
                shadow[15:8] <= rsp_data_i;
                half         <= 1'b1;
                step         <= '0;
              end
            end
            default: ;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/errcnt_mailbox_reader.sv
module errcnt_mailbox_reader
  import mbx_reader_pkg::*;
#(
  parameter int TMO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [TMO_W-1:0]  poll_limit_i,
  output logic [7:0]        bus_addr_o,
  output logic [7:0]        bus_wdata_o,
  output logic              bus_write_o,
  output logic              bus_read_o,
  input  logic [7:0]        bus_rdata_i,
  input  logic              bus_waitreq_i,
  output logic [31:0]       count_o,
  output logic              done_o,
  output logic              ack_err_o,
  output logic              tmo_err_o
);
  logic              req;
  bus_cmd_t          cmd;
  logic              rsp_valid;
  logic [DATA_W-1:0] rsp_data;
  logic              g_clr, g_hit, g_exp;

  mbx_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .req_o(req), .cmd_o(cmd),
    .rsp_valid_i(rsp_valid), .rsp_data_i(rsp_data),
    .guard_clr_o(g_clr), .guard_hit_o(g_hit), .guard_expire_i(g_exp),
    .count_o(count_o), .done_o(done_o),
    .ack_err_o(ack_err_o), .tmo_err_o(tmo_err_o)
  );

  mbx_poll_guard #(.TMO_W(TMO_W)) u_guard (
    .clk(clk), .rst_n(rst_n), .clr_i(g_clr), .hit_i(g_hit),
    .limit_i(poll_limit_i), .expire_o(g_exp)
  );

  mbx_bus_port u_port (
    .clk(clk), .rst_n(rst_n), .req_i(req), .cmd_i(cmd),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o),
    .bus_write_o(bus_write_o), .bus_read_o(bus_read_o),
    .bus_rdata_i(bus_rdata_i), .bus_waitreq_i(bus_waitreq_i)
  );
endmodule

// File: rtl/mbx_reader_chk.sv
module mbx_reader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  bus_addr_o,
  input logic [7:0]  bus_wdata_o,
  input logic        bus_write_o,
  input logic        bus_read_o,
  input logic        bus_waitreq_i,
  input logic [31:0] count_o,
  input logic        done_o,
  input logic        ack_err_o,
  input logic        tmo_err_o
);
  // R8
  one_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_read_o && bus_write_o));

  // R8
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_read_o || bus_write_o) && bus_waitreq_i |=>
      $stable(bus_addr_o) && $stable(bus_wdata_o) &&
      $stable(bus_read_o) && $stable(bus_write_o));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(count_o));

  // R9
  done_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !ack_err_o && !tmo_err_o);

  // R1
  write_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_write_o |-> (bus_addr_o inside {8'h84, 8'h85, 8'h86, 8'h87, 8'h90, 8'h8A}));

  // R3
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_err_o && tmo_err_o));
endmodule

bind errcnt_mailbox_reader mbx_reader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o),
  .bus_write_o(bus_write_o), .bus_read_o(bus_read_o), .bus_waitreq_i(bus_waitreq_i),
  .count_o(count_o), .done_o(done_o), .ack_err_o(ack_err_o), .tmo_err_o(tmo_err_o)
);

// File: tb/errcnt_mailbox_reader_tb.sv
module errcnt_mailbox_reader_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  poll_limit_i = 8'd1;
  logic [7:0]  bus_addr_o, bus_wdata_o, bus_rdata_i;
  logic        bus_write_o, bus_read_o, bus_waitreq_i;
  logic [31:0] count_o;
  logic        done_o, ack_err_o, tmo_err_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  errcnt_mailbox_reader #(.TMO_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .poll_limit_i(poll_limit_i),
    .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o), .bus_write_o(bus_write_o),
    .bus_read_o(bus_read_o), .bus_rdata_i(bus_rdata_i), .bus_waitreq_i(bus_waitreq_i),
    .count_o(count_o), .done_o(done_o), .ack_err_o(ack_err_o), .tmo_err_o(tmo_err_o)
  );

  // slave model settings
  int          m_busy = 0;
  int          m_wmode = 0;
  int          m_ackfail = 2;
  logic [31:0] m_value = '0;
  int          trig_n = 0;
  int          busy_left = 0;
  int          cyc = 0;
  int          done_n = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic [16:0] log_e [0:63];
  int          log_n = 0;
  logic [16:0] exp_e [0:63];
  int          exp_n = 0;

  initial begin
    bus_rdata_i   = 8'h00;
    bus_waitreq_i = 1'b0;
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (done_o) done_n = done_n + 1;
    bus_rdata_i <= 8'hC3 ^ lfsr[7:0];
    case (m_wmode)
      0:       bus_waitreq_i <= 1'b0;
      1:       bus_waitreq_i <= cyc[0];
      default: bus_waitreq_i <= lfsr[3];
    endcase
    if (rst_n && (bus_read_o || bus_write_o) && !bus_waitreq_i) begin
      if (log_n < 64) log_e[log_n] = {bus_write_o, bus_addr_o, bus_write_o ? bus_wdata_o : 8'h00};
      log_n = log_n + 1;
      if (bus_write_o && bus_addr_o == 8'h90) begin
        trig_n    = trig_n + 1;
        busy_left = m_busy;
      end
      if (bus_read_o) begin
        case (bus_addr_o)
          8'h8A: bus_rdata_i <= (m_ackfail == trig_n - 1) ? 8'h7F : 8'h80 | lfsr[6:0];
          8'h8B: begin
            if (busy_left > 0) begin
              busy_left = busy_left - 1;
              bus_rdata_i <= 8'h01 | {lfsr[6:0], 1'b0};
            end else bus_rdata_i <= {lfsr[6:0], 1'b0};
          end
          8'h88: bus_rdata_i <= (trig_n == 2) ? m_value[23:16] : m_value[7:0];
          8'h89: bus_rdata_i <= (trig_n == 2) ? m_value[31:24] : m_value[15:8];
          default: bus_rdata_i <= 8'h00;
        endcase
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic add(input logic we, input logic [7:0] a, input logic [7:0] d);
    exp_e[exp_n] = {we, a, d};
    exp_n++;
  endtask

  // outcome: 0 success, 1 ack error, 2 timeout
  task automatic build(input int b, input int leff, input int af, output int outcome);
    exp_n = 0;
    outcome = 0;
    for (int h = 0; h < 2; h++) begin
      add(1, 8'h84, 8'h00); add(1, 8'h85, 8'h00); add(1, 8'h86, 8'h1A);
      add(1, 8'h87, 8'h00); add(1, 8'h90, 8'h01); add(0, 8'h8A, 8'h00);
      if (af == h) begin outcome = 1; return; end
      if (b >= leff) begin
        for (int i = 0; i < leff; i++) add(0, 8'h8B, 8'h00);
        outcome = 2; return;
      end
      for (int i = 0; i <= b; i++) add(0, 8'h8B, 8'h00);
      add(1, 8'h8A, 8'h80); add(0, 8'h88, 8'h00); add(0, 8'h89, 8'h00);
    end
  endtask

  logic [31:0] last_count = '0;

  task automatic run(input int b, input int lim, input int wm, input int af,
                     input logic [31:0] val, input logic extra);
    int outcome, wait_c, mism;
    logic [31:0] prev;
    build(b, (lim == 0) ? 1 : lim, af, outcome);
    prev = count_o;
    @(negedge clk);
    m_busy = b; m_wmode = wm; m_ackfail = af; m_value = val;
    poll_limit_i = lim[7:0];
    trig_n = 0; log_n = 0; done_n = 0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // R10 flags cleared by accepted start
    chk(!ack_err_o && !tmo_err_o, "R10 flags cleared on start", {ack_err_o, tmo_err_o}, 0);
    if (extra) begin
      repeat (9) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    wait_c = 0;
    while (!done_o && !ack_err_o && !tmo_err_o && wait_c < 3000) begin
      @(negedge clk); wait_c++;
    end
    repeat (30) @(negedge clk);
    mism = -1;
    for (int i = 0; i < exp_n && i < log_n; i++)
      if (mism < 0 && log_e[i] !== exp_e[i]) mism = i;
    chk(log_n == exp_n, "R1 R2 R4 R5 R10 access count", log_n, exp_n);
    if (mism >= 0)
      chk(1'b0, "R1 R2 R3 R4 R5 R7 access order", {15'd0, log_e[mism]}, {15'd0, exp_e[mism]});
    else
      chk(1'b1, "R1 R2 R4 R5 access order", 0, 0);
    chk(ack_err_o == (outcome == 1), "R3 ack error flag", ack_err_o, outcome == 1);
    chk(tmo_err_o == (outcome == 2), "R7 timeout flag", tmo_err_o, outcome == 2);
    chk(done_n == (outcome == 0 ? 1 : 0), "R9 done pulses", done_n, outcome == 0);
    if (outcome == 0) begin
      chk(count_o == val, (wm != 0) ? "R6 R8 count under stalls" : "R6 count", count_o, val);
      last_count = val;
    end else
      chk(count_o == prev, "R9 count held on failure", count_o, prev);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(count_o == 0 && !done_o, "R9 reset count and done", count_o, 0);
    chk(!ack_err_o && !tmo_err_o, "R3 R7 reset flags", {ack_err_o, tmo_err_o}, 0);
    chk(!bus_read_o && !bus_write_o, "R8 bus idle in reset", {bus_read_o, bus_write_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!bus_read_o && !bus_write_o && log_n == 0, "R8 bus idle before start", log_n, 0);
    for (int wm = 0; wm < 3; wm++)
      for (int b = 0; b < 4; b++)
        for (int l = 0; l < 4; l++)
          run(b, l, wm, 2, 32'h9E3779B9 * (wm * 16 + b * 4 + l + 1), 1'b0);
    run(0, 2, 1, 0, 32'h11223344, 1'b0);  // R3 first pass
    run(1, 3, 2, 1, 32'h55667788, 1'b0);  // R3 second pass
    run(2, 5, 1, 2, 32'hDEADBEEF, 1'b1);  // R10 mid-sequence start
    run(0, 1, 0, 2, 32'hFFFF0000, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule